// File: doc/BRIEF.md
# Dual-Window Paravirtual Device Register File

This block holds the transport registers of a paravirtual device and serves them through two access windows chosen per request. Window 0 is a legacy port window. On that window a device-specific configuration area is laid over the register space, starting just past the last register that is live in the current interrupt setup. Window 1 is a memory-mapped mirror of the same registers, and it never shows that overlay. Windows 2 and 3 reach the configuration area directly, starting at offset 0. The registers cover a 64-bit host feature vector and a 64-bit guest feature vector, each read through a 32-bit slice picked by its own select register. They also cover queue selection, queue size, lower and upper page-frame words, a notify doorbell, device status, an interrupt status byte and two interrupt vector registers.

The overlay starts at byte 20 while message-signalled interrupts are off and at byte 36 while they are on. A driver removes the overlay for good by writing a 1 to the separate-config guest feature bit. The removal holds until reset, even if the bit is later cleared. The block also records whether the driver uses the legacy or the modern windows. It flags any access that mixes the two. Writing zero to the status register performs a device reset.

Every request is a single cycle with `req_valid` high. Its response appears on the registered outputs one clock later. Write data and read data are both right-justified, and all multi-byte fields are little-endian.

Top module: `dwin_regfile`

## Requirements
- R1: The register window places the following fields at these byte offsets: host feature slice at 0 (32 bit, read-only), guest feature slice at 4 (32), queue page frame at 8 (32), queue size at 12 (16, read-only), queue select at 14 (16), notify at 16 (16), status at 18 (8), interrupt status at 19 (8, read-only), config vector at 20 (16), queue vector at 22 (16), host select at 24 (32), guest select at 28 (32) and upper page frame at 32 (32). Multi-byte fields are little-endian. Offsets at 36 and above read as zero.
- R2: A feature select value of 0 shows bits 31:0 of its feature vector and a value of 1 shows bits 63:32. Any larger value reads as zero, and a guest feature write made while the guest select is above 1 is ignored.
- R3: A read that covers byte 19 returns the interrupt status and clears it in the same access. Bits on `isr_set` are ORed into the interrupt status on every clock.
- R4: In window 0, while the overlay is present, offsets at or above the overlay base reach the configuration area at (offset - base). The base is 20 while `msi_en` is 0 and 36 while it is 1. Offsets below the base reach the registers.
- R5: Writing a 1 to guest feature bit SEPCFG_BIT (24 by default) sets a latch. Once the latch is set, window 0 decodes as registers only. The latch stays set after the bit is cleared and is released only by a reset.
- R6: Window 1 always decodes as registers, whatever the latch holds. Windows 2 and 3 reach the configuration area from offset 0, and reads past its end return zero.
- R7: `mode` is 0 (unknown) after reset. The first aligned access moves it to 1 (legacy) if it came through window 0, or to 2 (modern) if it came through any other window. After that it holds until a reset.
- R8: An aligned access through window 0 while in modern mode, or through windows 1 to 3 while in legacy mode, raises `mode_err` for one cycle. The access itself is still carried out.
- R9: Sizes 0, 1 and 2 select byte, halfword and word. A halfword at an odd offset, a word at an offset that is not a multiple of 4, or size 3 is misaligned. A misaligned access returns zero and raises `rsp_err`, and it changes no state.
- R10: Writing 0 to the status byte performs a device reset. It clears the latch, the mode, the interrupt status, the queue select and every queue's page frame, upper page frame and vector. The configuration area and the interrupt config vector are kept.
- R11: The queue size reads as Q_DEPTH while the queue select is below NUM_Q and as zero otherwise. While the select is out of range, all per-queue fields read as zero and writes to them are ignored.
- R12: A write covering the notify bytes raises `notify_valid` for one cycle, with `notify_idx` set to the written halfword. Reads of the notify field return zero.
- R13: `rsp_valid` is high exactly one cycle after each cycle in which `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | 0 legacy, 1 mirror, 2/3 config window |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Right-justified write data |
| msi_en | input | 1 | Message-signalled interrupts enabled |
| host_feat | input | 64 | Features offered by the device |
| isr_set | input | 8 | Interrupt status bits to set |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Right-justified read data |
| rsp_err | output | 1 | Misaligned access |
| mode | output | 2 | Access mode: 0 unknown, 1 legacy, 2 modern |
| mode_err | output | 1 | Window mixing detected |
| notify_valid | output | 1 | Doorbell pulse |
| notify_idx | output | 16 | Queue index written to notify |

## Verification
All results of an access are due on the clock edge that samples the request: read data, `rsp_err`, `mode`, `mode_err`, `notify_valid` and every state change. Each bench access drives its inputs at a falling edge, waits one rising edge and samples all outputs at the next falling edge. The effect of one access is therefore read before the next one is driven. State that has no port of its own, such as the latch and the interrupt status, is checked by a later read through a window, with its expected value taken from the bench's own model of the register behaviour.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
   typedef enum logic [1:0] {MODE_UNKNOWN = 2'd0, MODE_LEGACY = 2'd1, MODE_MODERN = 2'd2} mode_e;
   typedef enum logic [1:0] {TGT_NONE = 2'd0, TGT_REG = 2'd1, TGT_CFG = 2'd2} tgt_e;

   localparam int REG_BYTES = 36;
   localparam int OVL_BASE_NOMSI = 20;
   localparam int OVL_BASE_MSI = 36;

   function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
      case (sz)
         2'd0: return 4'b0001 << off;
         2'd1: return 4'b0011 << off;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] feat_slice(input logic [31:0] sel, input logic [63:0] v);
      if (sel == 32'd0) return v[31:0];
      else if (sel == 32'd1) return v[63:32];
      else return 32'd0;
   endfunction
endpackage

// File: rtl/dwin_decode.sv
module dwin_decode import dwin_pkg::*; #(
   parameter int ADDR_W = 8,
   parameter int CFG_BYTES = 16
) (
   input  logic [1:0]        win,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              msi_en,
   input  logic              sep_latch,
   output logic              aligned,
   output tgt_e              tgt,
   output logic [ADDR_W-1:0] eff,
   output logic [3:0]        be
);
   localparam logic [ADDR_W-1:0] CFG_LIM = ADDR_W'(CFG_BYTES);
   localparam logic [ADDR_W-1:0] REG_LIM = ADDR_W'(REG_BYTES);
   localparam logic [ADDR_W-1:0] BASE_LO = ADDR_W'(OVL_BASE_NOMSI);
   localparam logic [ADDR_W-1:0] BASE_HI = ADDR_W'(OVL_BASE_MSI);

   logic [ADDR_W-1:0] base;
   logic              use_cfg;

   assign base = msi_en ? BASE_HI : BASE_LO;
   assign be   = lane_mask(size, addr[1:0]);

   always_comb begin
      case (size)
         2'd0: aligned = 1'b1;
         2'd1: aligned = !addr[0];
         2'd2: aligned = (addr[1:0] == 2'b00);
         default: aligned = 1'b0;
      endcase
   end

   always_comb begin
      use_cfg = 1'b0;
      eff     = addr;
      if (win[1]) begin
         use_cfg = 1'b1;
      end else if (win == 2'd0 && !sep_latch && addr >= base) begin
         use_cfg = 1'b1;
         eff     = addr - base;
      end
      if (use_cfg) tgt = (eff < CFG_LIM) ? TGT_CFG : TGT_NONE;
      else         tgt = (eff < REG_LIM) ? TGT_REG : TGT_NONE;
   end
endmodule

// File: rtl/dwin_mode_trk.sv
module dwin_mode_trk import dwin_pkg::*; (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  acc,
   input  logic  legacy_win,
   input  logic  dev_rst,
   output mode_e mode,
   output logic  mode_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= MODE_UNKNOWN;
         mode_err <= 1'b0;
      end else begin
         mode_err <= acc && ((mode == MODE_LEGACY && !legacy_win) ||
                             (mode == MODE_MODERN && legacy_win));
         if (dev_rst)
            mode <= MODE_UNKNOWN;
         else if (acc && mode == MODE_UNKNOWN)
            mode <= legacy_win ? MODE_LEGACY : MODE_MODERN;
      end
   end
endmodule

// File: rtl/dwin_cfg_ram.sv
module dwin_cfg_ram #(
   parameter int WORDS = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [3:0]    be,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);
   logic [31:0] words [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (we && widx == IW'(w)) begin
            for (int b = 0; b < 4; b++)
               if (be[b]) word_q[8*b +: 8] <= wdata[8*b +: 8];
         end
      end
      assign words[w] = word_q;
   end

   assign rdata = words[widx];
endmodule

// File: rtl/dwin_regfile.sv
module dwin_regfile import dwin_pkg::*; #(
   parameter int ADDR_W = 8,
   parameter int NUM_Q = 2,
   parameter int CFG_BYTES = 16,
   parameter int Q_DEPTH = 256,
   parameter int SEPCFG_BIT = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_win,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   input  logic              msi_en,
   input  logic [63:0]       host_feat,
   input  logic [7:0]        isr_set,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err,
   output logic [1:0]        mode,
   output logic              mode_err,
   output logic              notify_valid,
   output logic [15:0]       notify_idx
);
   localparam int CFG_WORDS = CFG_BYTES / 4;
   localparam int CW = $clog2(CFG_WORDS);
   localparam int QW = $clog2(NUM_Q);
   localparam int WW = ADDR_W - 2;

   if (NUM_Q < 2 || (NUM_Q & (NUM_Q - 1)) != 0) begin : g_bad_numq
      $error("NUM_Q must be a power of two, at least 2");
   end
   if (CFG_BYTES < 8 || (CFG_BYTES & (CFG_BYTES - 1)) != 0) begin : g_bad_cfg
      $error("CFG_BYTES must be a power of two, at least 8");
   end
   if (OVL_BASE_MSI + CFG_BYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the overlay");
   end
   if (SEPCFG_BIT < 0 || SEPCFG_BIT > 63 || Q_DEPTH > 65535) begin : g_bad_misc
      $error("SEPCFG_BIT or Q_DEPTH out of range");
   end

   // state
   logic [63:0] guest_feat;
   logic [31:0] host_fsel, guest_fsel;
   logic [15:0] qsel, msi_cfg_vec;
   logic [7:0]  status_q, isr_q;
   logic        sep_latch;
   logic [31:0] q_pfn    [NUM_Q];
   logic [31:0] q_pfn_hi [NUM_Q];
   logic [15:0] q_vec    [NUM_Q];

   // decode
   logic              aligned;
   tgt_e              tgt;
   logic [ADDR_W-1:0] eff;
   logic [3:0]        be;
   logic [WW-1:0]     widx;

   dwin_decode #(.ADDR_W(ADDR_W), .CFG_BYTES(CFG_BYTES)) u_dec (
      .win(req_win), .addr(req_addr), .size(req_size), .msi_en(msi_en),
      .sep_latch(sep_latch), .aligned(aligned), .tgt(tgt), .eff(eff), .be(be));

   assign widx = eff[ADDR_W-1:2];

   logic acc, wr, rd, reg_we, cfg_we, q_ok, dev_rst, isr_clr, gf_we;
   logic [QW-1:0] qi;
   logic [31:0] bm, wsh, reg_word, cfg_word, rword, merged, rsh, rd_data;
   logic [63:0] gf_next;

   assign acc    = req_valid && aligned;
   assign wr     = acc && req_write;
   assign rd     = acc && !req_write;
   assign reg_we = wr && tgt == TGT_REG;
   assign cfg_we = wr && tgt == TGT_CFG;
   assign qi     = qsel[QW-1:0];
   assign q_ok   = qsel < 16'(NUM_Q);
   assign bm     = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   assign wsh    = req_wdata << {eff[1:0], 3'b000};

   dwin_cfg_ram #(.WORDS(CFG_WORDS), .IW(CW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(widx[CW-1:0]), .be(be),
      .wdata(wsh), .rdata(cfg_word));

   always_comb begin
      case (widx)
         WW'(0): reg_word = feat_slice(host_fsel, host_feat);
         WW'(1): reg_word = feat_slice(guest_fsel, guest_feat);
         WW'(2): reg_word = q_ok ? q_pfn[qi] : 32'd0;
         WW'(3): reg_word = {qsel, q_ok ? 16'(Q_DEPTH) : 16'd0};
         WW'(4): reg_word = {isr_q, status_q, 16'd0};
         WW'(5): reg_word = {q_ok ? q_vec[qi] : 16'd0, msi_cfg_vec};
         WW'(6): reg_word = host_fsel;
         WW'(7): reg_word = guest_fsel;
         WW'(8): reg_word = q_ok ? q_pfn_hi[qi] : 32'd0;
         default: reg_word = 32'd0;
      endcase
   end

   always_comb begin
      case (tgt)
         TGT_REG: rword = reg_word;
         TGT_CFG: rword = cfg_word;
         default: rword = 32'd0;
      endcase
      merged = (rword & ~bm) | (wsh & bm);
      rsh    = rword >> {eff[1:0], 3'b000};
      case (req_size)
         2'd0:    rd_data = {24'd0, rsh[7:0]};
         2'd1:    rd_data = {16'd0, rsh[15:0]};
         default: rd_data = rsh;
      endcase
   end

   assign dev_rst = reg_we && widx == WW'(4) && be[2] && merged[23:16] == 8'd0;
   assign isr_clr = rd && tgt == TGT_REG && widx == WW'(4) && be[3];
   assign gf_we   = reg_we && widx == WW'(1) && guest_fsel < 32'd2;
   assign gf_next = guest_fsel[0] ? {merged, guest_feat[31:0]} : {guest_feat[63:32], merged};

   mode_e mode_q;
   dwin_mode_trk u_mode (
      .clk(clk), .rst_n(rst_n), .acc(acc), .legacy_win(req_win == 2'd0),
      .dev_rst(dev_rst), .mode(mode_q), .mode_err(mode_err));
   assign mode = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_err <= 1'b0;
         notify_valid <= 1'b0; notify_idx <= '0;
         guest_feat <= '0; host_fsel <= '0; guest_fsel <= '0;
         qsel <= '0; msi_cfg_vec <= '0; status_q <= '0; isr_q <= '0;
         sep_latch <= 1'b0;
         for (int q = 0; q < NUM_Q; q++) begin
            q_pfn[q] <= '0; q_pfn_hi[q] <= '0; q_vec[q] <= '0;
         end
      end else begin
         rsp_valid    <= req_valid;
         rsp_err      <= req_valid && !aligned;
         rsp_rdata    <= rd ? rd_data : 32'd0;
         notify_valid <= 1'b0;
         isr_q        <= (isr_clr ? 8'd0 : isr_q) | isr_set;
         if (gf_we) begin
            guest_feat <= gf_next;
            if (gf_next[SEPCFG_BIT]) sep_latch <= 1'b1;
         end
         if (reg_we) begin
            case (widx)
               WW'(2): if (q_ok) q_pfn[qi] <= merged;
               WW'(3): if (be[2] || be[3]) qsel <= merged[31:16];
               WW'(4): begin
                  if (be[0] || be[1]) begin
                     notify_valid <= 1'b1;
                     notify_idx   <= merged[15:0];
                  end
                  if (be[2]) status_q <= merged[23:16];
               end
               WW'(5): begin
                  if (be[0] || be[1]) msi_cfg_vec <= merged[15:0];
                  if ((be[2] || be[3]) && q_ok) q_vec[qi] <= merged[31:16];
               end
               WW'(6): host_fsel <= merged;
               WW'(7): guest_fsel <= merged;
               WW'(8): if (q_ok) q_pfn_hi[qi] <= merged;
               default: ;
            endcase
         end
         if (dev_rst) begin
            sep_latch <= 1'b0;
            isr_q     <= isr_set;
            qsel      <= '0;
            for (int q = 0; q < NUM_Q; q++) begin
               q_pfn[q] <= '0; q_pfn_hi[q] <= '0; q_vec[q] <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/dwin_regfile_chk.sv
module dwin_regfile_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_win,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic [7:0]        isr_set,
   input logic [7:0]        isr_q,
   input logic              rsp_valid,
   input logic [31:0]       rsp_rdata,
   input logic              rsp_err,
   input logic [1:0]        mode,
   input logic              mode_err,
   input logic              notify_valid
);
   logic al;
   assign al = (req_size == 2'd0) || (req_size == 2'd1 && !req_addr[0]) ||
               (req_size == 2'd2 && req_addr[1:0] == 2'b00);

   p_rsp_due_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !al) |=> (rsp_err && rsp_rdata == 32'd0));
   p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0) |=> (mode == $past(mode) || mode == 2'd0));
   p_mix_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && al && mode == 2'd1 && req_win != 2'd0) |=> mode_err);
   p_isr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_win == 2'd1 && req_addr == ADDR_W'(19) &&
       req_size == 2'd0 && isr_set == 8'd0) |=> isr_q == 8'd0);
   p_notify_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
      notify_valid |-> $past(req_valid && req_write));
endmodule

bind dwin_regfile dwin_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_win(req_win), .req_addr(req_addr), .req_size(req_size),
   .isr_set(isr_set), .isr_q(isr_q), .rsp_valid(rsp_valid),
   .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mode(mode),
   .mode_err(mode_err), .notify_valid(notify_valid));

// File: tb/dwin_regfile_tb.sv
module dwin_regfile_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] HOST_F = 64'h0123_4567_89AB_CDEF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, msi_en = 1'b0;
   logic [1:0] req_win = '0, req_size = '0;
   logic [7:0] req_addr = '0, isr_set = '0;
   logic [31:0] req_wdata = '0;
   logic rsp_valid, rsp_err, mode_err, notify_valid;
   logic [31:0] rsp_rdata;
   logic [1:0] mode;
   logic [15:0] notify_idx;

   int nchk = 0, nerr = 0;
   logic [31:0] pfn_m [4];
   logic [7:0]  cfg_m [16];
   logic [15:0] qsel_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   dwin_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_win(req_win), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .msi_en(msi_en), .host_feat(HOST_F),
      .isr_set(isr_set), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .mode(mode), .mode_err(mode_err),
      .notify_valid(notify_valid), .notify_idx(notify_idx));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic [1:0] w, input logic wr, input logic [7:0] a,
                      input logic [1:0] sz, input logic [31:0] d,
                      output logic [31:0] rdv, output logic er);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_win = w; req_addr = a;
      req_size = sz; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      rdv = rsp_rdata; er = rsp_err;
   endtask

   task automatic wr(input logic [1:0] w, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] d);
      logic [31:0] r; logic e;
      acc(w, 1'b1, a, sz, d, r, e);
   endtask

   task automatic rdchk(input string tag, input logic [1:0] w, input logic [7:0] a,
                        input logic [1:0] sz, input logic [31:0] exp);
      logic [31:0] r; logic e;
      acc(w, 1'b0, a, sz, 32'd0, r, e);
      check(tag, r, exp);
   endtask

   task automatic pulse_isr(input logic [7:0] v);
      @(negedge clk); isr_set = v;
      @(negedge clk); isr_set = 8'd0;
   endtask

   function automatic logic [31:0] cfg_word_m(input int i);
      return {cfg_m[4*i+3], cfg_m[4*i+2], cfg_m[4*i+1], cfg_m[4*i]};
   endfunction

   function automatic logic [31:0] slice_m(input logic [31:0] sel, input logic [63:0] v);
      return (sel == 0) ? v[31:0] : (sel == 1) ? v[63:32] : 32'd0;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [31:0] r; logic e;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 reset mode", 32'(mode), 0);
      check("R13 idle rsp_valid", 32'(rsp_valid), 0);

      // R1 / R7 / R13
      acc(2'd1, 1'b0, 8'd0, 2'd2, 0, r, e);
      check("R1 host low slice", r, slice_m(0, HOST_F));
      check("R13 rsp_valid", 32'(rsp_valid), 1);
      check("R7 mirror -> modern", 32'(mode), 2);
      // R2 host select
      wr(2'd1, 8'd24, 2'd2, 1);
      rdchk("R2 host high slice", 2'd1, 8'd0, 2'd2, slice_m(1, HOST_F));
      wr(2'd1, 8'd24, 2'd2, 2);
      rdchk("R2 host sel 2 zero", 2'd1, 8'd0, 2'd2, 0);
      wr(2'd1, 8'd24, 2'd2, 0);
      // R2 guest select
      wr(2'd1, 8'd28, 2'd2, 1);
      wr(2'd1, 8'd4, 2'd2, 32'h0000_DEAD);
      wr(2'd1, 8'd28, 2'd2, 3);
      wr(2'd1, 8'd4, 2'd2, 32'hFFFF_FFFF);
      rdchk("R2 guest sel 3 zero", 2'd1, 8'd4, 2'd2, 0);
      wr(2'd1, 8'd28, 2'd2, 1);
      rdchk("R2 guest write ignored", 2'd1, 8'd4, 2'd2, 32'h0000_DEAD);
      wr(2'd1, 8'd28, 2'd2, 0);

      // R6 config window fill
      for (int i = 0; i < 4; i++) begin
         logic [31:0] d = 32'hC0DE_0000 | 32'(i);
         wr(2'd2, 8'(4*i), 2'd2, d);
         for (int b = 0; b < 4; b++) cfg_m[4*i+b] = d[8*b +: 8];
      end
      rdchk("R6 config window word2", 2'd2, 8'd8, 2'd2, cfg_word_m(2));
      rdchk("R6 config window past end", 2'd3, 8'd16, 2'd2, 0);

      // R11 / R1 queues
      wr(2'd1, 8'd14, 2'd1, 1);
      wr(2'd1, 8'd8, 2'd2, 32'h1111_2222);
      wr(2'd1, 8'd32, 2'd2, 32'h0000_ABCD);
      wr(2'd1, 8'd22, 2'd1, 16'h0077);
      rdchk("R11 queue size", 2'd1, 8'd12, 2'd1, 256);
      rdchk("R1 LE byte 9", 2'd1, 8'd9, 2'd0, 32'h22);
      rdchk("R1 LE half 10", 2'd1, 8'd10, 2'd1, 32'h1111);
      wr(2'd1, 8'd14, 2'd1, 0);
      rdchk("R11 queue0 pfn", 2'd1, 8'd8, 2'd2, 0);
      wr(2'd1, 8'd14, 2'd1, 7);
      rdchk("R11 oob size zero", 2'd1, 8'd12, 2'd1, 0);
      wr(2'd1, 8'd8, 2'd2, 32'hFFFF);
      rdchk("R11 oob pfn zero", 2'd1, 8'd8, 2'd2, 0);
      rdchk("R11 oob vec zero", 2'd1, 8'd22, 2'd1, 0);
      wr(2'd1, 8'd14, 2'd1, 1);
      rdchk("R11 queue1 pfn kept", 2'd1, 8'd8, 2'd2, 32'h1111_2222);
      rdchk("R1 upper pfn", 2'd1, 8'd32, 2'd2, 32'h0000_ABCD);
      rdchk("R1 queue vector", 2'd1, 8'd22, 2'd1, 32'h77);

      // R12 notify
      wr(2'd1, 8'd16, 2'd1, 3);
      check("R12 notify pulse", 32'(notify_valid), 1);
      check("R12 notify index", 32'(notify_idx), 3);
      rdchk("R12 notify reads zero", 2'd1, 8'd16, 2'd1, 0);
      check("R12 pulse one cycle", 32'(notify_valid), 0);

      // R3 isr
      pulse_isr(8'h05);
      rdchk("R3 isr read", 2'd1, 8'd19, 2'd0, 32'h05);
      rdchk("R3 isr cleared", 2'd1, 8'd19, 2'd0, 0);

      // R9 misaligned
      acc(2'd1, 1'b0, 8'd13, 2'd1, 0, r, e);
      check("R9 odd half err", 32'(e), 1);
      check("R9 odd half data", r, 0);
      acc(2'd1, 1'b1, 8'd9, 2'd1, 32'h5555, r, e);
      check("R9 misaligned write err", 32'(e), 1);
      rdchk("R9 no side effect", 2'd1, 8'd8, 2'd2, 32'h1111_2222);
      acc(2'd1, 1'b0, 8'd0, 2'd3, 0, r, e);
      check("R9 size 3 err", 32'(e), 1);

      // R8 mixing
      acc(2'd0, 1'b0, 8'd18, 2'd0, 0, r, e);
      check("R8 legacy in modern flagged", 32'(mode_err), 1);
      check("R8 mode kept", 32'(mode), 2);
      rdchk("R8 mirror access", 2'd1, 8'd18, 2'd0, 0);
      check("R8 no flag when matched", 32'(mode_err), 0);

      // R10 device reset
      pulse_isr(8'h03);
      wr(2'd1, 8'd18, 2'd0, 0);
      check("R10 mode cleared", 32'(mode), 0);
      rdchk("R10 isr cleared", 2'd1, 8'd19, 2'd0, 0);
      rdchk("R10 qsel cleared", 2'd1, 8'd14, 2'd1, 0);
      wr(2'd1, 8'd14, 2'd1, 1);
      rdchk("R10 pfn cleared", 2'd1, 8'd8, 2'd2, 0);
      rdchk("R10 queue vector cleared", 2'd1, 8'd22, 2'd1, 0);

      // R4 legacy overlay
      wr(2'd1, 8'd18, 2'd0, 0);
      msi_en = 1'b0;
      rdchk("R4 overlay at 20", 2'd0, 8'd20, 2'd2, cfg_word_m(0));
      check("R7 legacy mode", 32'(mode), 1);
      rdchk("R4 overlay byte 23", 2'd0, 8'd23, 2'd0, 32'(cfg_m[3]));
      msi_en = 1'b1;
      wr(2'd0, 8'd20, 2'd1, 16'h0042);
      rdchk("R4 overlay at 36", 2'd0, 8'd36, 2'd2, cfg_word_m(0));
      rdchk("R4 register below base", 2'd0, 8'd20, 2'd1, 32'h42);

      // R5 separate-config latch
      wr(2'd0, 8'd4, 2'd2, 32'h0100_0000);
      wr(2'd0, 8'd4, 2'd2, 0);
      msi_en = 1'b0;
      rdchk("R5 overlay removed", 2'd0, 8'd20, 2'd1, 32'h42);
      rdchk("R5 beyond regs zero", 2'd0, 8'd36, 2'd2, 0);

      // R10 latch release, R6 mirror never overlays
      wr(2'd0, 8'd18, 2'd0, 0);
      rdchk("R10 latch released", 2'd0, 8'd20, 2'd2, cfg_word_m(0));
      rdchk("R6 mirror shows registers", 2'd1, 8'd20, 2'd1, 32'h42);
      check("R8 mirror in legacy flagged", 32'(mode_err), 1);

      // random phase through modern windows
      wr(2'd1, 8'd18, 2'd0, 0);
      for (int q = 0; q < 4; q++) pfn_m[q] = 0;
      qsel_m = 0;
      for (int n = 0; n < 300; n++) begin
         int op = int'($urandom % 4);
         if (op == 0) begin
            qsel_m = 16'($urandom % 4);
            wr(2'd1, 8'd14, 2'd1, 32'(qsel_m));
         end else if (op == 1) begin
            logic [31:0] v = $urandom;
            wr(2'd1, 8'd8, 2'd2, v);
            if (qsel_m < 2) pfn_m[qsel_m] = v;
         end else if (op == 2) begin
            rdchk("R11 random pfn", 2'd1, 8'd8, 2'd2, (qsel_m < 2) ? pfn_m[qsel_m] : 32'd0);
         end else begin
            int a = int'($urandom % 16);
            logic [7:0] d = 8'($urandom);
            wr(2'd2, 8'(a), 2'd0, 32'(d));
            cfg_m[a] = d;
            rdchk("R6 random config", 2'd2, 8'(a & ~3), 2'd2, cfg_word_m(a / 4));
         end
      end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule